// File: doc/BRIEF.md
# Fault Flag Response Controller

This block watches thirteen protection flag lines: overcurrent, overvoltage, undervoltage, overtemperature, AC sense and one external flag. It decides which of three PWM channels (A, B, C) may run. Each flag carries two programmable choices. The first is what to switch off when the flag asserts: nothing, channel A, channel B, or every channel. The second is how the affected channels come back once the flag drops: at once, after a global delay followed by a soft start, or only after a fresh power-on request edge.

The block drives one enable line and one soft-start request per channel. The PWM generators and the soft-start ramp sit outside it. The ramp reports completion on a single done input. Flags are also captured into sticky status bits, which software clears by writing ones, or which follow the flag lines directly when a parameter selects that variant. Configuration arrives as bytes on a simple address/data write port.

Top module: `fault_response_ctrl`

## Requirements
- R1: After reset all three PWM enables are high, no soft-start request is raised, every status bit is zero and every flag is configured to take no action.
- R2: A flag's 2-bit set-action code decides which enables it drops: 00 drops none, 01 drops channel A (bit 0), 10 drops channel B (bit 1), and 11 drops A, B and C. Channel C (bit 2) is dropped only by code 11.
- R3: Configuration byte at address k (0 to 5) holds flag 2k in bits [3:0] and flag 2k+1 in bits [7:4]. Inside a nibble, bits [3:2] are the set action and bits [1:0] the release mode. Address 6 holds flag 12 in bits [3:0] and the delay select in bits [7:6]. Address 7 changes nothing.
- R4: A channel's enable is low from the cycle after any targeting flag is sampled high, and stays low while any flag that targets it is still high.
- R5: Release mode 01 re-enables the channel in the cycle after the last targeting flag drops, with no soft-start request.
- R6: Release mode 00 re-enables the channel exactly DELAY_BASE << sel cycles after the last targeting flag drops, and raises that channel's soft-start request together with the enable. Here sel is the 2-bit delay select.
- R7: Release mode 10 or 11 keeps the channel off until a rising edge on the power-on request. A level held high since before the fault does not release it. The edge restarts the channel through soft start.
- R8: When several flags hit a channel during one fault episode, the most restrictive release mode applies: power-on wait over delayed soft start over immediate.
- R9: A soft-start request stays high until the done input is sampled high. It then drops while the enable stays high.
- R10: Status bit f is set the cycle after flag f is sampled high and stays set after the flag drops. A write-one-to-clear pulse clears the selected bits, but a flag still high in that cycle keeps its bit set. Unselected bits are untouched.
- R11: A flag that reasserts while its channel waits for the delay or for the power-on edge returns the channel to the held state. The delay then restarts from zero after the flag drops again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flagIn | input | 13 | Protection flag lines, active high |
| psonReq | input | 1 | Power-on request level; rising edge releases waiting channels |
| ssDone | input | 1 | Soft-start ramp finished |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration byte address |
| cfgWrData | input | 8 | Configuration byte |
| stsClrEn | input | 1 | Status clear strobe |
| stsClrMask | input | 13 | Status bits to clear (ones clear) |
| pwmEn | output | 3 | PWM enable per channel, bit 0 = A, bit 1 = B, bit 2 = C |
| ssReq | output | 3 | Soft-start request per channel |
| flagSts | output | 13 | Sticky flag status |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a write-one-to-clear pulse and a flag that is still asserted hit the same status bit. The bench holds a flag high while clearing its bit together with a bit whose flag has dropped. It expects only the second bit to clear. In the second, two flags with different release modes target one channel and drop in the same cycle, or in a chosen order. The bench judges which release path wins by the exact cycle the enable returns and by whether a soft-start request comes with it.

// File: rtl/ffr_pkg.sv
package ffr_pkg;
  localparam int NUM_FLAGS = 13;
  localparam int NUM_CH    = 3;
  localparam int NUM_CFG   = 7;
  localparam int CFG_AW    = 3;
  localparam int CH_A      = 0;
  localparam int CH_B      = 1;

  // Release rank: larger value is more restrictive
  typedef enum logic [1:0] {
    REL_IMM   = 2'd0,
    REL_DELAY = 2'd1,
    REL_PSON  = 2'd2
  } relRank_t;

  typedef enum logic [2:0] {
    CH_RUN,
    CH_HELD,
    CH_WAIT_DLY,
    CH_WAIT_PSON,
    CH_SOFT
  } chState_t;

  typedef struct packed {
    logic cntClr;
    logic cntEn;
    logic modeClr;
  } chStrobe_t;

  function automatic relRank_t rankOf(input logic [1:0] aft);
    case (aft)
      2'b01:   return REL_IMM;
      2'b00:   return REL_DELAY;
      default: return REL_PSON;
    endcase
  endfunction

  function automatic logic hitsChannel(input logic [1:0] act, input int ch);
    return (act == 2'b11) ||
           (act == 2'b01 && ch == CH_A) ||
           (act == 2'b10 && ch == CH_B);
  endfunction
endpackage

// File: rtl/ffr_datapath.sv
module ffr_datapath
  import ffr_pkg::*;
#(
  parameter int DELAY_BASE          = 1000,
  parameter bit STS_CLR_ON_DEASSERT = 1'b0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_FLAGS-1:0]     flagIn,
  input  logic                     psonReq,
  input  logic                     cfgWrEn,
  input  logic [CFG_AW-1:0]        cfgAddr,
  input  logic [7:0]               cfgWrData,
  input  logic                     stsClrEn,
  input  logic [NUM_FLAGS-1:0]     stsClrMask,
  input  chStrobe_t [NUM_CH-1:0]   strobe,
  output logic [NUM_CH-1:0]        chHold,
  output relRank_t [NUM_CH-1:0]    chMode,
  output logic [NUM_CH-1:0]        cntDone,
  output logic                     psonRise,
  output logic [NUM_FLAGS-1:0]     flagSts
);
  localparam int CNT_W = $clog2(DELAY_BASE * 8) + 1;

  logic [3:0]       cfgNib [NUM_FLAGS];
  logic [1:0]       delaySel;
  logic             psonQ;
  logic [CNT_W-1:0] delayLimit;

  // Configuration storage: flag f lives in byte f/2, nibble f%2
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int f = 0; f < NUM_FLAGS; f++) cfgNib[f] <= '0;
      delaySel <= '0;
    end else if (cfgWrEn) begin
      for (int f = 0; f < NUM_FLAGS; f++) begin
        if (cfgAddr == CFG_AW'(f / 2))
          cfgNib[f] <= (f % 2 == 1) ? cfgWrData[7:4] : cfgWrData[3:0];
      end
      if (cfgAddr == CFG_AW'(NUM_CFG - 1)) delaySel <= cfgWrData[7:6];
    end
  end

  assign delayLimit = CNT_W'(DELAY_BASE) << delaySel;

  // Power-on request edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) psonQ <= 1'b0;
    else       psonQ <= psonReq;
  end
  assign psonRise = psonReq & ~psonQ;

  // Per-channel hold, release-mode accumulation and delay counter
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             holdC;
    relRank_t         worstC;
    relRank_t         modeQ;
    logic [CNT_W-1:0] cnt;

    always_comb begin
      holdC  = 1'b0;
      worstC = REL_IMM;
      for (int f = 0; f < NUM_FLAGS; f++) begin
        if (flagIn[f] && hitsChannel(cfgNib[f][3:2], c)) begin
          holdC = 1'b1;
          if (rankOf(cfgNib[f][1:0]) > worstC) worstC = rankOf(cfgNib[f][1:0]);
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         modeQ <= REL_IMM;
      else if (strobe[c].modeClr)        modeQ <= REL_IMM;
      else if (holdC && worstC > modeQ)  modeQ <= worstC;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  cnt <= '0;
      else if (strobe[c].cntClr)  cnt <= '0;
      else if (strobe[c].cntEn)   cnt <= cnt + 1'b1;
    end

    assign chHold[c]  = holdC;
    assign chMode[c]  = modeQ;
    assign cntDone[c] = (cnt >= delayLimit - 1'b1);
  end

  // Sticky status, variant picked by parameter
  if (STS_CLR_ON_DEASSERT) begin : g_sts_follow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagSts <= '0;
      else       flagSts <= flagIn;
    end
    logic unusedClr;
    assign unusedClr = stsClrEn ^ (^stsClrMask);
  end else begin : g_sts_w1c
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagSts <= '0;
      else       flagSts <= flagIn | (flagSts & ~(stsClrEn ? stsClrMask : '0));
    end
  end
endmodule

// File: rtl/ffr_control.sv
module ffr_control
  import ffr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_CH-1:0]      chHold,
  input  relRank_t [NUM_CH-1:0]  chMode,
  input  logic [NUM_CH-1:0]      cntDone,
  input  logic                   psonRise,
  input  logic                   ssDone,
  output chStrobe_t [NUM_CH-1:0] strobe,
  output logic [NUM_CH-1:0]      pwmEn,
  output logic [NUM_CH-1:0]      ssReq
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_fsm
    chState_t  state, stateNxt;
    chStrobe_t stb;

    always_comb begin
      stateNxt = state;
      stb      = '0;
      unique case (state)
        CH_RUN: if (chHold[c]) stateNxt = CH_HELD;
        CH_HELD: begin
          if (!chHold[c]) begin
            unique case (chMode[c])
              REL_IMM: begin
                stateNxt    = CH_RUN;
                stb.modeClr = 1'b1;
              end
              REL_DELAY: begin
                stateNxt   = CH_WAIT_DLY;
                stb.cntClr = 1'b1;
              end
              default: stateNxt = CH_WAIT_PSON;
            endcase
          end
        end
        CH_WAIT_DLY: begin
          if (chHold[c]) stateNxt = CH_HELD;
          else begin
            stb.cntEn = 1'b1;
            if (cntDone[c]) begin
              stateNxt    = CH_SOFT;
              stb.modeClr = 1'b1;
            end
          end
        end
        CH_WAIT_PSON: begin
          if (chHold[c]) stateNxt = CH_HELD;
          else if (psonRise) begin
            stateNxt    = CH_SOFT;
            stb.modeClr = 1'b1;
          end
        end
        CH_SOFT: begin
          if (chHold[c])   stateNxt = CH_HELD;
          else if (ssDone) stateNxt = CH_RUN;
        end
        default: stateNxt = CH_HELD;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) state <= CH_RUN;
      else       state <= stateNxt;
    end

    assign strobe[c] = stb;
    assign pwmEn[c]  = (state == CH_RUN) || (state == CH_SOFT);
    assign ssReq[c]  = (state == CH_SOFT);
  end
endmodule

// File: rtl/fault_response_ctrl.sv
module fault_response_ctrl
  import ffr_pkg::*;
#(
  parameter int DELAY_BASE          = 1000,
  parameter bit STS_CLR_ON_DEASSERT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] flagIn,
  input  logic                 psonReq,
  input  logic                 ssDone,
  input  logic                 cfgWrEn,
  input  logic [CFG_AW-1:0]    cfgAddr,
  input  logic [7:0]           cfgWrData,
  input  logic                 stsClrEn,
  input  logic [NUM_FLAGS-1:0] stsClrMask,
  output logic [NUM_CH-1:0]    pwmEn,
  output logic [NUM_CH-1:0]    ssReq,
  output logic [NUM_FLAGS-1:0] flagSts
);
  chStrobe_t [NUM_CH-1:0] strobe;
  logic [NUM_CH-1:0]      chHold;
  relRank_t [NUM_CH-1:0]  chMode;
  logic [NUM_CH-1:0]      cntDone;
  logic                   psonRise;

  ffr_datapath #(
    .DELAY_BASE         (DELAY_BASE),
    .STS_CLR_ON_DEASSERT(STS_CLR_ON_DEASSERT)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .flagIn    (flagIn),
    .psonReq   (psonReq),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .stsClrEn  (stsClrEn),
    .stsClrMask(stsClrMask),
    .strobe    (strobe),
    .chHold    (chHold),
    .chMode    (chMode),
    .cntDone   (cntDone),
    .psonRise  (psonRise),
    .flagSts   (flagSts)
  );

  ffr_control i_control (
    .clk     (clk),
    .rstN    (rstN),
    .chHold  (chHold),
    .chMode  (chMode),
    .cntDone (cntDone),
    .psonRise(psonRise),
    .ssDone  (ssDone),
    .strobe  (strobe),
    .pwmEn   (pwmEn),
    .ssReq   (ssReq)
  );
endmodule

// File: rtl/ffr_checker.sv
module ffr_checker
  import ffr_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_CH-1:0]    pwmEn,
  input logic [NUM_CH-1:0]    ssReq,
  input logic [NUM_CH-1:0]    chHold,
  input logic                 ssDone,
  input logic [NUM_FLAGS-1:0] flagIn,
  input logic [NUM_FLAGS-1:0] flagSts
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk_ch
    assert_hold_off_R4: assert property (@(posedge clk) disable iff (!rstN)
      chHold[c] |=> !pwmEn[c]);

    assert_off_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
      $fell(pwmEn[c]) |-> $past(chHold[c]));

    assert_ss_with_pwm_R9: assert property (@(posedge clk) disable iff (!rstN)
      ssReq[c] |-> pwmEn[c]);

    assert_ss_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
      (ssReq[c] && !ssDone && !chHold[c]) |=> ssReq[c]);
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_chk_flag
    assert_sts_set_R10: assert property (@(posedge clk) disable iff (!rstN)
      flagIn[f] |=> flagSts[f]);
  end
endmodule

bind fault_response_ctrl ffr_checker i_ffr_checker (
  .clk    (clk),
  .rstN   (rstN),
  .pwmEn  (pwmEn),
  .ssReq  (ssReq),
  .chHold (chHold),
  .ssDone (ssDone),
  .flagIn (flagIn),
  .flagSts(flagSts)
);

// File: tb/test_fault_response_ctrl.sv
module test_fault_response_ctrl;
  localparam int BASE  = 8;
  localparam int LIMIT = BASE << 1;  // delay select 01

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] flagIn = '0;
  logic        psonReq = 1'b0;
  logic        ssDone = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [7:0]  cfgWrData = '0;
  logic        stsClrEn = 1'b0;
  logic [12:0] stsClrMask = '0;
  logic [2:0]  pwmEn;
  logic [2:0]  ssReq;
  logic [12:0] flagSts;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fault_response_ctrl #(.DELAY_BASE(BASE), .STS_CLR_ON_DEASSERT(1'b0)) i_fault_response_ctrl (
    .clk(clk), .rstN(rstN), .flagIn(flagIn), .psonReq(psonReq), .ssDone(ssDone),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .stsClrEn(stsClrEn), .stsClrMask(stsClrMask),
    .pwmEn(pwmEn), .ssReq(ssReq), .flagSts(flagSts)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] a, input logic [7:0] d);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    step(1);
    cfgWrEn = 1'b0;
  endtask

  task automatic pulseDone();
    ssDone = 1'b1;
    step(1);
    ssDone = 1'b0;
  endtask

  task automatic testReset();
    step(3);
    rstN = 1'b1;
    step(1);
    check("R1 pwm", 32'(pwmEn), 32'h7);
    check("R1 ss", 32'(ssReq), 32'h0);
    check("R1 sts", 32'(flagSts), 32'h0);
    flagIn[0] = 1'b1;
    step(1);
    check("R1 default no action", 32'(pwmEn), 32'h7);
    flagIn[0] = 1'b0;
    step(1);
  endtask

  task automatic testDecode();
    cfgWrite(3'd0, 8'h95);        // flag0: A/imm, flag1: B/imm
    cfgWrite(3'd6, 8'h4D);        // flag12: all/imm, delay select 01
    cfgWrite(3'd7, 8'hFF);        // unused address
    flagIn[0] = 1'b1; step(1);
    check("R2 R3 flag0 drops A", 32'(pwmEn), 32'h6);
    flagIn[0] = 1'b0; step(1);
    check("R5 immediate back", 32'(pwmEn), 32'h7);
    check("R5 no soft start", 32'(ssReq), 32'h0);
    flagIn[1] = 1'b1; step(1);
    check("R2 R3 flag1 drops B", 32'(pwmEn), 32'h5);
    flagIn[1] = 1'b0; step(1);
    flagIn[12] = 1'b1; step(1);
    check("R2 R3 flag12 drops all incl C", 32'(pwmEn), 32'h0);
    flagIn[12] = 1'b0; step(1);
    check("R5 all back", 32'(pwmEn), 32'h7);
    flagIn[2] = 1'b1; step(1);
    check("R3 address 7 ignored", 32'(pwmEn), 32'h7);
    flagIn[2] = 1'b0; step(1);
  endtask

  task automatic testHold();
    cfgWrite(3'd1, 8'h50);        // flag3: A/imm
    flagIn[0] = 1'b1; flagIn[3] = 1'b1; step(1);
    check("R4 both hold A", 32'(pwmEn), 32'h6);
    flagIn[0] = 1'b0; step(2);
    check("R4 still held by flag3", 32'(pwmEn), 32'h6);
    flagIn[3] = 1'b0; step(1);
    check("R4 released", 32'(pwmEn), 32'h7);
  endtask

  task automatic testDelay();
    cfgWrite(3'd2, 8'h08);        // flag4: B/delayed
    flagIn[4] = 1'b1; step(1);
    check("R6 held", 32'(pwmEn), 32'h5);
    flagIn[4] = 1'b0; step(LIMIT);
    check("R6 off one cycle before limit", 32'(pwmEn), 32'h5);
    step(1);
    check("R6 on at limit", 32'(pwmEn), 32'h7);
    check("R6 soft start req", 32'(ssReq), 32'h2);
    step(3);
    check("R9 req held without done", 32'(ssReq), 32'h2);
    pulseDone();
    check("R9 req drops", 32'(ssReq), 32'h0);
    check("R9 pwm stays", 32'(pwmEn), 32'h7);
  endtask

  task automatic testPson();
    cfgWrite(3'd2, 8'hE8);        // flag5: all/pson, flag4 kept
    psonReq = 1'b1; step(1);
    flagIn[5] = 1'b1; step(1);
    check("R7 all off", 32'(pwmEn), 32'h0);
    flagIn[5] = 1'b0; step(5);
    check("R7 level does not release", 32'(pwmEn), 32'h0);
    psonReq = 1'b0; step(1);
    check("R7 still off", 32'(pwmEn), 32'h0);
    psonReq = 1'b1; step(1);
    check("R7 edge releases", 32'(pwmEn), 32'h7);
    check("R7 via soft start", 32'(ssReq), 32'h7);
    pulseDone();
    check("R9 done clears all", 32'(ssReq), 32'h0);
  endtask

  task automatic testPriority();
    cfgWrite(3'd3, 8'h65);        // flag6: A/imm, flag7: A/pson
    cfgWrite(3'd4, 8'h04);        // flag8: A/delayed
    flagIn[6] = 1'b1; flagIn[7] = 1'b1; step(1);
    flagIn[7] = 1'b0; step(1);
    flagIn[6] = 1'b0; step(3);
    check("R8 pson beats immediate", 32'(pwmEn), 32'h6);
    psonReq = 1'b0; step(1);
    psonReq = 1'b1; step(1);
    check("R8 released by edge", 32'(pwmEn), 32'h7);
    check("R8 soft start A", 32'(ssReq), 32'h1);
    pulseDone();
    flagIn[6] = 1'b1; flagIn[8] = 1'b1; step(1);
    flagIn[6] = 1'b0; flagIn[8] = 1'b0; step(1);
    check("R8 delayed beats immediate", 32'(pwmEn), 32'h6);
    step(LIMIT - 1);
    check("R8 still waiting", 32'(pwmEn), 32'h6);
    step(1);
    check("R8 back after delay", 32'(pwmEn), 32'h7);
    check("R8 delayed soft start", 32'(ssReq), 32'h1);
    pulseDone();
  endtask

  task automatic testReassert();
    flagIn[4] = 1'b1; step(1);
    flagIn[4] = 1'b0; step(5);
    flagIn[4] = 1'b1; step(1);
    check("R11 held again", 32'(pwmEn), 32'h5);
    step(20);
    check("R11 held beyond limit", 32'(pwmEn), 32'h5);
    flagIn[4] = 1'b0; step(LIMIT);
    check("R11 delay restarted", 32'(pwmEn), 32'h5);
    step(1);
    check("R11 back", 32'(pwmEn), 32'h7);
    pulseDone();
  endtask

  task automatic testStatus();
    check("R10 sticky from earlier flags", 32'(flagSts[4]), 32'h1);
    stsClrEn = 1'b1; stsClrMask = '1; step(1);
    stsClrEn = 1'b0; stsClrMask = '0;
    check("R10 cleared all", 32'(flagSts), 32'h0);
    flagIn[9] = 1'b1; step(1);
    check("R10 set", 32'(flagSts), 32'h200);
    check("R2 action none", 32'(pwmEn), 32'h7);
    flagIn[9] = 1'b0; flagIn[10] = 1'b1; step(1);
    check("R10 sticky after drop", 32'(flagSts), 32'h600);
    stsClrEn = 1'b1; stsClrMask = 13'h800; step(1);
    check("R10 unselected untouched", 32'(flagSts), 32'h600);
    stsClrMask = 13'h600; step(1);
    stsClrEn = 1'b0; stsClrMask = '0;
    check("R10 set wins over clear", 32'(flagSts), 32'h400);
    flagIn[10] = 1'b0; step(1);
  endtask

  initial begin
    testReset();
    testDecode();
    testHold();
    testDelay();
    testPson();
    testPriority();
    testReassert();
    testStatus();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule